// File: doc/BRIEF.md
# Merging Write Store Buffer

This block sits between a write source and the path that drains writes into a cache or to main memory. It holds bufferable writes in a small set of line-sized entries. A write arrives with a byte address, a 64-bit data beat, an 8-bit byte strobe and a non-secure flag. If it lands in a line that is already held in a younger entry with the same non-secure flag, its strobed bytes are folded into that entry. Otherwise it opens a fresh entry.

The non-secure flag counts as one more address bit for matching. A secure write and a non-secure write to the same byte address therefore always occupy separate entries.

Entries leave through a valid/ready drain port, oldest first. Each one carries its line address, its non-secure flag, the full 256-bit line and a 32-bit byte mask of the bytes actually written. The drain side decides whether a line goes to the cache or to memory; this block does not make that choice.

The entry currently offered on the drain port is closed: no new bytes can be merged into it. A write to that line goes to a new entry instead, so the data on the drain port cannot change while it waits.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the drain port is idle (`dr_valid` low) and `wr_ready` is high for a bufferable write.
- R2: An accepted bufferable write with a non-zero strobe that matches no open entry takes a new entry. The line address is `wr_addr[31:5]` and the beat slot is `wr_addr[4:3]`. Strobe bit k places data byte k at line byte slot*8+k and sets mask bit slot*8+k. Bytes never written drain as zero with their mask bits clear.
- R3: A write whose line address and non-secure flag equal those of an open entry that is not on the drain port merges into that entry. Each newer strobed byte replaces the older byte, the mask becomes the OR of both, and no further entry is taken.
- R4: Writes to the same line with different non-secure flags never merge; each one drains as its own line with its own flag.
- R5: Entries drain strictly in the order they were opened, and `dr_valid` is high whenever at least one entry is held.
- R6: The entry presented on the drain port accepts no merge; a write to its line and flag opens a new entry.
- R7: When all three entries are held and a bufferable write with a non-zero strobe matches none of them, `wr_ready` is low. It rises in the cycle after a drain handshake completes, never in the handshake cycle itself. A merging write is still accepted while all entries are full.
- R8: While `dr_valid` is high and `dr_ready` is low, the drain address, flag, data and mask hold steady. A handshake frees the entry.
- R9: A write with `wr_bufferable` low sees `wr_ready` low and leaves no trace in the buffer.
- R10: A bufferable write with an all-zero strobe is accepted but takes no entry and changes no held line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken this cycle |
| wr_addr | input | 32 | Byte address of the write beat |
| wr_ns | input | 1 | Non-secure flag of the write |
| wr_bufferable | input | 1 | Write may be held in the buffer |
| wr_data | input | 64 | Write data beat |
| wr_strb | input | 8 | Byte strobes of the beat |
| dr_valid | output | 1 | A line is offered for draining |
| dr_ready | input | 1 | Drain side takes the offered line |
| dr_addr | output | 27 | Line address of the offered entry |
| dr_ns | output | 1 | Non-secure flag of the offered entry |
| dr_data | output | 256 | Line data of the offered entry |
| dr_mask | output | 32 | Byte-valid mask of the offered entry |

## Verification
The bench first runs a sweep over every beat slot and a set of strobe shapes (single low byte, single high byte, alternating, contiguous middle, full). Each write goes to a fresh line and is drained at once, which isolates byte placement and mask building from merging. Overlapping and disjoint writes are then piled onto one held line, which shows whether newer bytes overwrite older ones and whether the mask accumulates. Further sequences cover a secure/non-secure pair on one line, a write aimed at the line on the drain port, and a full buffer meeting both a missing write and a merging one; these separate the match rules from the allocation and stall rules. A long mixed run reuses a handful of lines with drains interleaved, so merges, new entries and oldest-first order all occur together.

// File: rtl/smb_pkg.sv
package smb_pkg;
   parameter int unsigned SMB_ADDR_W     = 32;
   parameter int unsigned SMB_IN_BYTES   = 8;
   parameter int unsigned SMB_LINE_BYTES = 32;
   parameter int unsigned SMB_ENTRIES    = 3;
endpackage

// File: rtl/smb_beat_place.sv
module smb_beat_place #(
   parameter int unsigned IN_BYTES   = smb_pkg::SMB_IN_BYTES,
   parameter int unsigned LINE_BYTES = smb_pkg::SMB_LINE_BYTES,
   localparam int unsigned SLOTS    = LINE_BYTES / IN_BYTES,
   localparam int unsigned OFS_W    = $clog2(LINE_BYTES),
   localparam int unsigned BEAT_OFS = $clog2(IN_BYTES),
   localparam int unsigned SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic [OFS_W-1:0]        ofs,
   input  logic [IN_BYTES*8-1:0]   beat,
   input  logic [IN_BYTES-1:0]     strb,
   output logic [LINE_BYTES-1:0]   byte_en,
   output logic [LINE_BYTES*8-1:0] line_data
);
   if (LINE_BYTES % IN_BYTES != 0) begin : g_bad_ratio
      $error("smb_beat_place: line size must be a multiple of the beat size");
   end
   if ((SLOTS & (SLOTS - 1)) != 0) begin : g_bad_pow2
      $error("smb_beat_place: beats per line must be a power of two");
   end

   logic [SLOT_W-1:0] slot;

   if (SLOTS > 1) begin : g_multi
      assign slot = ofs[BEAT_OFS +: SLOT_W];
      if (BEAT_OFS > 0) begin : g_low
         wire unused_low = ^ofs[BEAT_OFS-1:0];
      end
   end else begin : g_single
      assign slot = '0;
      wire unused_ofs = ^ofs;
   end

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         for (int b = 0; b < IN_BYTES; b++) begin
            byte_en[s*IN_BYTES + b] = (slot == SLOT_W'(s)) && strb[b];
         end
      end
   end

   assign line_data = {SLOTS{beat}};
endmodule

// File: rtl/smb_entry.sv
module smb_entry #(
   parameter int unsigned LINE_BYTES = smb_pkg::SMB_LINE_BYTES,
   parameter int unsigned LA_W       = 27,
   localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  open_i,
   input  logic                  fold_i,
   input  logic                  retire_i,
   input  logic [LA_W-1:0]       in_line,
   input  logic                  in_ns,
   input  logic [LINE_BYTES-1:0] in_en,
   input  logic [LINE_W-1:0]     in_data,
   output logic                  busy_o,
   output logic [LA_W-1:0]       line_o,
   output logic                  ns_o,
   output logic [LINE_W-1:0]     data_o,
   output logic [LINE_BYTES-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         line_o <= '0;
         ns_o   <= 1'b0;
         data_o <= '0;
         mask_o <= '0;
      end else if (open_i) begin
         busy_o <= 1'b1;
         line_o <= in_line;
         ns_o   <= in_ns;
         mask_o <= in_en;
         for (int b = 0; b < LINE_BYTES; b++) begin
            data_o[b*8 +: 8] <= in_en[b] ? in_data[b*8 +: 8] : 8'h00;
         end
      end else if (fold_i) begin
         mask_o <= mask_o | in_en;
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (in_en[b]) data_o[b*8 +: 8] <= in_data[b*8 +: 8];
         end
      end else if (retire_i) begin
         busy_o <= 1'b0;
      end
   end
endmodule

// File: rtl/smb_age.sv
module smb_age #(
   parameter int unsigned ENTRIES = smb_pkg::SMB_ENTRIES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] busy,
   input  logic [ENTRIES-1:0] open_vec,
   output logic [ENTRIES-1:0] oldest
);
   // older_than[i][j] set: entry j was opened before entry i
   logic [ENTRIES-1:0][ENTRIES-1:0] older_than;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_than <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            for (int j = 0; j < ENTRIES; j++) begin
               if (i != j) begin
                  if (open_vec[i])      older_than[i][j] <= 1'b1;
                  else if (open_vec[j]) older_than[i][j] <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         logic blocked;
         blocked = 1'b0;
         for (int j = 0; j < ENTRIES; j++) begin
            blocked = blocked | (busy[j] & older_than[i][j]);
         end
         oldest[i] = busy[i] & ~blocked;
      end
   end
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
   parameter int unsigned ADDR_W     = smb_pkg::SMB_ADDR_W,
   parameter int unsigned IN_BYTES   = smb_pkg::SMB_IN_BYTES,
   parameter int unsigned LINE_BYTES = smb_pkg::SMB_LINE_BYTES,
   parameter int unsigned ENTRIES    = smb_pkg::SMB_ENTRIES,
   localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
   localparam int unsigned LA_W      = ADDR_W - OFS_W,
   localparam int unsigned LINE_W    = LINE_BYTES * 8,
   localparam int unsigned IN_W      = IN_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   output logic                  wr_ready,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic                  wr_ns,
   input  logic                  wr_bufferable,
   input  logic [IN_W-1:0]       wr_data,
   input  logic [IN_BYTES-1:0]   wr_strb,
   output logic                  dr_valid,
   input  logic                  dr_ready,
   output logic [LA_W-1:0]       dr_addr,
   output logic                  dr_ns,
   output logic [LINE_W-1:0]     dr_data,
   output logic [LINE_BYTES-1:0] dr_mask
);
   if (ENTRIES < 1) begin : g_bad_entries
      $error("store_merge_buffer: at least one entry is needed");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("store_merge_buffer: address narrower than the line offset");
   end
   if (LINE_BYTES < 2 || IN_BYTES > LINE_BYTES) begin : g_bad_line
      $error("store_merge_buffer: beat must fit inside a line of two or more bytes");
   end

   logic [ENTRIES-1:0]    ent_valid;
   logic [ENTRIES-1:0]    ent_ns;
   logic [LA_W-1:0]       ent_line [ENTRIES];
   logic [LINE_W-1:0]     ent_data [ENTRIES];
   logic [LINE_BYTES-1:0] ent_mask [ENTRIES];

   logic [ENTRIES-1:0]    head;
   logic [ENTRIES-1:0]    hit;
   logic [ENTRIES-1:0]    first_free;
   logic [ENTRIES-1:0]    open_vec;
   logic [ENTRIES-1:0]    fold_vec;
   logic [ENTRIES-1:0]    retire_vec;
   logic                  have_free;
   logic                  any_hit;
   logic                  strb_any;
   logic                  wr_fire;
   logic                  dr_fire;

   logic [LA_W-1:0]       wr_line;
   logic [LINE_BYTES-1:0] wr_en_line;
   logic [LINE_W-1:0]     wr_data_line;

   assign wr_line  = wr_addr[ADDR_W-1:OFS_W];
   assign strb_any = |wr_strb;

   smb_beat_place #(
      .IN_BYTES  (IN_BYTES),
      .LINE_BYTES(LINE_BYTES)
   ) u_place (
      .ofs      (wr_addr[OFS_W-1:0]),
      .beat     (wr_data),
      .strb     (wr_strb),
      .byte_en  (wr_en_line),
      .line_data(wr_data_line)
   );

   smb_age #(
      .ENTRIES(ENTRIES)
   ) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (ent_valid),
      .open_vec(open_vec),
      .oldest  (head)
   );

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         hit[i] = ent_valid[i] && !head[i] &&
                  (ent_line[i] == wr_line) && (ent_ns[i] == wr_ns);
      end
   end
   assign any_hit = |hit;

   always_comb begin
      first_free = '0;
      have_free  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!ent_valid[i] && !have_free) begin
            first_free[i] = 1'b1;
            have_free     = 1'b1;
         end
      end
   end

   assign wr_ready   = wr_bufferable && (!strb_any || any_hit || have_free);
   assign wr_fire    = wr_valid && wr_ready && strb_any;
   assign fold_vec   = wr_fire ? hit : '0;
   assign open_vec   = (wr_fire && !any_hit) ? first_free : '0;

   assign dr_valid   = |head;
   assign dr_fire    = dr_valid && dr_ready;
   assign retire_vec = dr_fire ? head : '0;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      smb_entry #(
         .LINE_BYTES(LINE_BYTES),
         .LA_W      (LA_W)
      ) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .open_i  (open_vec[g]),
         .fold_i  (fold_vec[g]),
         .retire_i(retire_vec[g]),
         .in_line (wr_line),
         .in_ns   (wr_ns),
         .in_en   (wr_en_line),
         .in_data (wr_data_line),
         .busy_o  (ent_valid[g]),
         .line_o  (ent_line[g]),
         .ns_o    (ent_ns[g]),
         .data_o  (ent_data[g]),
         .mask_o  (ent_mask[g])
      );
   end

   always_comb begin
      dr_addr = '0;
      dr_ns   = 1'b0;
      dr_data = '0;
      dr_mask = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         dr_addr = dr_addr | ({LA_W{head[i]}} & ent_line[i]);
         dr_ns   = dr_ns | (head[i] & ent_ns[i]);
         dr_data = dr_data | ({LINE_W{head[i]}} & ent_data[i]);
         dr_mask = dr_mask | ({LINE_BYTES{head[i]}} & ent_mask[i]);
      end
   end
endmodule

// File: rtl/store_merge_buffer_chk.sv
module store_merge_buffer_chk #(
   parameter int unsigned ENTRIES    = 3,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned IN_BYTES   = 8,
   parameter int unsigned LA_W       = 27
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_valid,
   input logic                    wr_ready,
   input logic                    wr_bufferable,
   input logic [IN_BYTES-1:0]     wr_strb,
   input logic                    dr_valid,
   input logic                    dr_ready,
   input logic [LA_W-1:0]         dr_addr,
   input logic                    dr_ns,
   input logic [LINE_BYTES*8-1:0] dr_data,
   input logic [LINE_BYTES-1:0]   dr_mask,
   input logic [ENTRIES-1:0]      ent_valid,
   input logic [ENTRIES-1:0]      ent_hit
);
   p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && |wr_strb && !(|ent_hit) && !(dr_valid && dr_ready))
      |=> $countones(ent_valid) == $past($countones(ent_valid)) + 1);

   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ent_hit));

   p_merge_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && |wr_strb && |ent_hit && !(dr_valid && dr_ready))
      |=> $countones(ent_valid) == $past($countones(ent_valid)));

   p_drain_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid == (|ent_valid));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&ent_valid && wr_valid && wr_bufferable && |wr_strb && !(|ent_hit))
      |-> !wr_ready);

   p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_ns)
                                   && $stable(dr_data) && $stable(dr_mask)));

   p_nonbuf_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_bufferable) |-> !wr_ready);

   p_zero_strb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_strb == '0 && !(dr_valid && dr_ready))
      |=> $stable(ent_valid));
endmodule

bind store_merge_buffer store_merge_buffer_chk #(
   .ENTRIES   (ENTRIES),
   .LINE_BYTES(LINE_BYTES),
   .IN_BYTES  (IN_BYTES),
   .LA_W      (LA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .wr_bufferable(wr_bufferable),
   .wr_strb      (wr_strb),
   .dr_valid     (dr_valid),
   .dr_ready     (dr_ready),
   .dr_addr      (dr_addr),
   .dr_ns        (dr_ns),
   .dr_data      (dr_data),
   .dr_mask      (dr_mask),
   .ent_valid    (ent_valid),
   .ent_hit      (hit)
);

// File: tb/store_merge_buffer_tb.sv
module store_merge_buffer_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic         wr_ready;
   logic [31:0]  wr_addr = '0;
   logic         wr_ns = 1'b0;
   logic         wr_bufferable = 1'b1;
   logic [63:0]  wr_data = '0;
   logic [7:0]   wr_strb = '0;
   logic         dr_valid;
   logic         dr_ready = 1'b0;
   logic [26:0]  dr_addr;
   logic         dr_ns;
   logic [255:0] dr_data;
   logic [31:0]  dr_mask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expected contents, index 0 is the oldest entry
   logic [26:0]  m_line [3];
   bit           m_ns   [3];
   logic [255:0] m_data [3];
   logic [31:0]  m_mask [3];
   int           m_n = 0;

   always #2 clk = ~clk;

   store_merge_buffer u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_ns(wr_ns), .wr_bufferable(wr_bufferable), .wr_data(wr_data),
      .wr_strb(wr_strb),
      .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
      .dr_ns(dr_ns), .dr_data(dr_data), .dr_mask(dr_mask)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] beat(input int seed);
      return {32'(seed * 32'h9E3779B1), 32'(seed) ^ 32'hA5A5_0F0F};
   endfunction

   // drives one write for a cycle, checks wr_ready, updates the model
   task automatic wr(input logic [31:0] a, input bit ns, input bit bf,
                     input logic [63:0] d, input logic [7:0] s, input string tag);
      logic [26:0] ln;
      int slot;
      int mi;
      bit exp_rdy;
      ln   = a[31:5];
      slot = int'(a[4:3]);
      mi   = -1;
      for (int i = 1; i < m_n; i++)
         if (m_line[i] == ln && m_ns[i] == ns) mi = i;
      exp_rdy = bf && (s == 8'h00 || mi >= 0 || m_n < 3);
      wr_valid = 1'b1; wr_addr = a; wr_ns = ns; wr_bufferable = bf;
      wr_data = d; wr_strb = s;
      #1;
      chk(wr_ready == exp_rdy, {tag, " wr_ready"}, 256'(wr_ready), 256'(exp_rdy));
      @(posedge clk); #1;
      wr_valid = 1'b0; wr_bufferable = 1'b1;
      if (exp_rdy && s != 8'h00) begin
         if (mi < 0) begin
            mi = m_n; m_n++;
            m_line[mi] = ln; m_ns[mi] = ns; m_data[mi] = '0; m_mask[mi] = '0;
         end
         for (int k = 0; k < 8; k++) begin
            if (s[k]) begin
               m_data[mi][(slot*8+k)*8 +: 8] = d[k*8 +: 8];
               m_mask[mi][slot*8+k] = 1'b1;
            end
         end
      end
   endtask

   task automatic cmp_head(input string tag);
      chk(dr_valid == (m_n > 0), {tag, " dr_valid"}, 256'(dr_valid), 256'(m_n > 0));
      if (m_n > 0) begin
         chk(dr_addr == m_line[0], {tag, " dr_addr"}, 256'(dr_addr), 256'(m_line[0]));
         chk(dr_ns == m_ns[0], {tag, " dr_ns"}, 256'(dr_ns), 256'(m_ns[0]));
         chk(dr_data == m_data[0], {tag, " dr_data"}, dr_data, m_data[0]);
         chk(dr_mask == m_mask[0], {tag, " dr_mask"}, 256'(dr_mask), 256'(m_mask[0]));
      end
   endtask

   task automatic drn(input string tag);
      cmp_head(tag);
      dr_ready = 1'b1;
      @(posedge clk); #1;
      dr_ready = 1'b0;
      if (m_n > 0) begin
         for (int i = 0; i < 2; i++) begin
            m_line[i] = m_line[i+1]; m_ns[i] = m_ns[i+1];
            m_data[i] = m_data[i+1]; m_mask[i] = m_mask[i+1];
         end
         m_n--;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] pats [5];
      pats[0] = 8'h01; pats[1] = 8'h80; pats[2] = 8'hA5; pats[3] = 8'h3C; pats[4] = 8'hFF;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      wr_strb = 8'h01; #1;
      chk(dr_valid == 1'b0, "R1 dr_valid after reset", 256'(dr_valid), 256'(0));
      chk(wr_ready == 1'b1, "R1 wr_ready after reset", 256'(wr_ready), 256'(1));
      wr_strb = 8'h00;
      @(posedge clk); #1;

      // R9 non-bufferable is refused
      wr(32'h0000_1008, 1'b0, 1'b0, beat(1), 8'hFF, "R9 nonbuf");
      cmp_head("R9 nothing held");

      // R10 zero strobe accepted, nothing held
      wr(32'h0000_2010, 1'b0, 1'b1, beat(2), 8'h00, "R10 zero strobe");
      cmp_head("R10 nothing held");

      // R2 sweep: every slot and strobe shape into a fresh line
      for (int p = 0; p < 5; p++) begin
         for (int sl = 0; sl < 4; sl++) begin
            wr({22'h00_0100 + 22'(p*4 + sl), 5'(sl << 3), 5'b0} >> 0 ? 32'((32'h4000 + (p*4+sl)) << 5) | 32'(sl << 3) : 32'h0,
               p[0], 1'b1, beat(10 + p*4 + sl), pats[p], "R2 place");
            drn("R2 drain placed beat");
         end
      end

      // R3 merges with overlap; newer bytes win, mask accumulates
      wr(32'h0001_0008, 1'b0, 1'b1, beat(30), 8'hFF, "R3 open head");
      wr(32'h0002_0000, 1'b0, 1'b1, beat(31), 8'hF0, "R3 open target");
      wr(32'h0002_0000, 1'b0, 1'b1, beat(32), 8'h3C, "R3 overlap merge");
      wr(32'h0002_0018, 1'b0, 1'b1, beat(33), 8'hFF, "R3 other slot merge");
      wr(32'h0002_0000, 1'b0, 1'b1, beat(34), 8'h01, "R3 low byte merge");
      chk(m_n == 2, "R3 model entries", 256'(m_n), 256'(2));
      drn("R5 oldest first");
      drn("R3 merged line");
      cmp_head("R3 no extra entry");

      // R4 + R7: NS separation, full with hit and with miss
      wr(32'h0003_0000, 1'b0, 1'b1, beat(40), 8'h0F, "R4 head");
      wr(32'h0004_0008, 1'b0, 1'b1, beat(41), 8'h0F, "R4 secure line");
      wr(32'h0004_0008, 1'b1, 1'b1, beat(42), 8'hF0, "R4 non-secure same line");
      chk(m_n == 3, "R4 separate entries", 256'(m_n), 256'(3));
      wr(32'h0004_0010, 1'b0, 1'b1, beat(43), 8'hFF, "R7 merge while full");
      wr(32'h0005_0000, 1'b0, 1'b1, beat(44), 8'hFF, "R7 stall on miss");
      // R8 payload held while drain side stalls
      cmp_head("R8 hold a");
      @(posedge clk); #1;
      cmp_head("R8 hold b");
      // R7 no ready in the handshake cycle itself
      wr_valid = 1'b1; wr_addr = 32'h0005_0000; wr_ns = 1'b0; wr_data = beat(44);
      wr_strb = 8'hFF; dr_ready = 1'b1; #1;
      chk(wr_ready == 1'b0, "R7 ready low during drain handshake", 256'(wr_ready), 256'(0));
      cmp_head("R8 drain while stalled");
      @(posedge clk); #1;
      dr_ready = 1'b0; wr_valid = 1'b0;
      for (int i = 0; i < 2; i++) begin
         m_line[i] = m_line[i+1]; m_ns[i] = m_ns[i+1];
         m_data[i] = m_data[i+1]; m_mask[i] = m_mask[i+1];
      end
      m_n--;
      wr(32'h0005_0000, 1'b0, 1'b1, beat(44), 8'hFF, "R7 ready after drain");
      drn("R4 secure line drains");
      drn("R4 non-secure line drains");
      drn("R7 late entry drains");

      // R6 head is closed to merges
      wr(32'h0006_0000, 1'b1, 1'b1, beat(50), 8'h0F, "R6 head open");
      wr(32'h0006_0000, 1'b1, 1'b1, beat(51), 8'hFF, "R6 same line new entry");
      chk(m_n == 2, "R6 two entries", 256'(m_n), 256'(2));
      drn("R6 first copy");
      drn("R6 second copy");

      // R5 mixed run over a few lines with interleaved drains
      for (int it = 0; it < 90; it++) begin
         wr(32'((32'h700 + (it % 4)) << 5) | 32'((it % 4) << 3), (it % 5) == 0, 1'b1,
            beat(100 + it), 8'((it * 37) % 256), "R5 mixed write");
         if (it % 3 == 2) drn("R5 mixed drain");
      end
      while (m_n > 0) drn("R5 final drain");
      cmp_head("R5 empty at end");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule